// File: doc/BRIEF.md
# SCSI Initiator DMA Receive Handshake

This block is the inbound data path of a SCSI initiator. It takes bytes from a target over the REQ/ACK handshake and passes each one to a host DMA engine. The host programs an expected bus phase and can enable DMA mode, then writes a start strobe. For each byte, the block waits for the target's REQ, captures the data bus, asserts ACK and holds it until REQ falls. Only when the handshake has fully closed does it raise a DMA request toward the host.

In DMA mode the block moves on to the next byte by itself once the host has taken the previous one. It watches BSY and the bus phase the whole time. If the target leaves the bus, or the phase no longer matches the programmed one, DMA mode is cancelled, the DMA request is dropped and an end-of-DMA flag is raised. A small register window gives the host the mode, the expected phase, a status word and the captured byte.

Top module: `scsi_dma_rx`

## Requirements
- R1: After reset `scsi_ack` and `dma_req` are low, and the mode register (address 0) and target-phase register (address 1) read as 0x00.
- R2: Status bit 1 (phase match) reads 1 exactly when the synchronised bus lines {MSG, C/D, I/O} equal bits [2:0] of the target-phase register, with MSG compared to bit 2 and I/O to bit 0.
- R3: A host write to address 3 starts the reception of one byte, and `scsi_ack` is asserted only after REQ has been seen high.
- R4: Once asserted, `scsi_ack` stays high for as long as REQ stays high, and it drops after REQ is seen low.
- R5: `dma_req` and status bit 2 rise on the same clock edge on which `scsi_ack` falls at the end of a completed handshake, and never while `scsi_ack` is high.
- R6: While `dma_req` is high, a new REQ is not acknowledged. A one-cycle `dma_rd` pulse clears `dma_req`.
- R7: With mode bit 1 (DMA enable) set, the next byte is accepted without another start write. With mode bit 1 clear, the block goes idle after one byte and acknowledges no further REQ.
- R8: With mode bit 1 set, a low BSY or a phase mismatch clears mode bit 1, sets status bit 0 (end of DMA), clears `dma_req`, and releases `scsi_ack` without completing the byte in progress.
- R9: With mode bit 1 clear, a low BSY or a phase mismatch leaves `dma_req` and status bit 0 unchanged.
- R10: `dma_data`, and a host read of address 4, return the byte captured in the last handshake.
- R11: A host write to the mode register clears status bit 0.
- R12: The mode and target-phase registers read back the last value written to them. Status bits 3, 4 and 5 show synchronised BSY, synchronised REQ and `scsi_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_wr | input | 1 | Host register write strobe |
| host_addr | input | 3 | Host register address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data for `host_addr` |
| scsi_req | input | 1 | Target REQ |
| scsi_bsy | input | 1 | BSY line |
| scsi_msg | input | 1 | MSG phase line |
| scsi_cd | input | 1 | C/D phase line |
| scsi_io | input | 1 | I/O phase line |
| scsi_data | input | 8 | SCSI data bus |
| scsi_ack | output | 1 | Initiator ACK |
| dma_req | output | 1 | DMA request to the host |
| dma_rd | input | 1 | DMA read strobe, takes the byte and clears the request |
| dma_data | output | 8 | Captured byte |

## Verification
The embedded assertions check the cycle-level ordering on every clock. ACK never coexists with a pending DMA request, ACK rises only after REQ and is held while REQ stays high, the DMA request appears on the edge where ACK falls, and a termination removes both DMA mode and the request. Other behaviours need whole sequences and are shown only by the bench scenarios: the phase-match decode across random phase and register values, automatic continuation in DMA mode against the single-byte stop otherwise, BSY loss being ignored outside DMA mode, and the captured byte matching what the target drove.

// File: rtl/scsi_rx_pkg.sv
package scsi_rx_pkg;

  // Host register window
  localparam int REG_MODE  = 0;
  localparam int REG_TCMD  = 1;
  localparam int REG_STAT  = 2;
  localparam int REG_START = 3;
  localparam int REG_DATA  = 4;

  // Mode register: DMA enable bit position
  localparam int MODE_DMA_BIT = 1;

  // Status word bit positions
  localparam int ST_EOD = 0;
  localparam int ST_PM  = 1;
  localparam int ST_DRQ = 2;
  localparam int ST_BSY = 3;
  localparam int ST_REQ = 4;
  localparam int ST_ACK = 5;

  // Bus phase: MSG is the most significant bit
  localparam int PHASE_W = 3;

  typedef struct packed {
    logic msg;
    logic cd;
    logic io;
  } phase_t;

  typedef enum logic [1:0] {
    HS_IDLE     = 2'd0,
    HS_WAIT_REQ = 2'd1,
    HS_WAIT_REL = 2'd2
  } hs_state_e;

endpackage

// File: rtl/scsi_rx_sync.sv
module scsi_rx_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  generate
    if (STAGES <= 1) begin : g_single
      logic [WIDTH-1:0] stage_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage_q <= '0;
        end else begin
          stage_q <= d;
        end
      end
      assign q = stage_q;
    end else begin : g_chain
      logic [STAGES-1:0][WIDTH-1:0] stage_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage_q <= '0;
        end else begin
          stage_q <= {stage_q[STAGES-2:0], d};
        end
      end
      assign q = stage_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/scsi_rx_regs.sv
module scsi_rx_regs
  import scsi_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              term_i,
  input  phase_t            bus_phase_i,
  input  logic              bsy_i,
  input  logic              req_i,
  input  logic              ack_i,
  input  logic              drq_i,
  input  logic              eod_i,
  input  logic [DATA_W-1:0] latch_i,
  output logic [DATA_W-1:0] host_rdata,
  output logic              dma_mode_o,
  output logic              start_o,
  output logic              mode_wr_o,
  output logic              pm_o
);

  logic [DATA_W-1:0] mode_q, mode_d;
  logic [DATA_W-1:0] tcmd_q, tcmd_d;
  logic              mode_en, tcmd_en;
  logic [DATA_W-1:0] stat_w;
  phase_t            want_phase;

  // Address decode
  always_comb begin
    mode_en   = host_wr && (host_addr == ADDR_W'(REG_MODE));
    tcmd_en   = host_wr && (host_addr == ADDR_W'(REG_TCMD));
    start_o   = host_wr && (host_addr == ADDR_W'(REG_START));
    mode_wr_o = mode_en;
  end

  // Next-state for the mode register: a termination always wins the DMA bit
  always_comb begin
    mode_d = mode_q;
    if (mode_en) begin
      mode_d = host_wdata;
    end
    if (term_i) begin
      mode_d[MODE_DMA_BIT] = 1'b0;
    end
  end

  always_comb begin
    tcmd_d = tcmd_q;
    if (tcmd_en) begin
      tcmd_d = host_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      tcmd_q <= '0;
    end else begin
      if (mode_en || term_i) begin
        mode_q <= mode_d;
      end
      if (tcmd_en) begin
        tcmd_q <= tcmd_d;
      end
    end
  end

  assign dma_mode_o = mode_q[MODE_DMA_BIT];

  // Phase comparison against the programmed expectation
  assign want_phase = phase_t'(tcmd_q[PHASE_W-1:0]);
  assign pm_o       = (bus_phase_i == want_phase);

  always_comb begin
    stat_w         = '0;
    stat_w[ST_EOD] = eod_i;
    stat_w[ST_PM]  = pm_o;
    stat_w[ST_DRQ] = drq_i;
    stat_w[ST_BSY] = bsy_i;
    stat_w[ST_REQ] = req_i;
    stat_w[ST_ACK] = ack_i;
  end

  // Read mux
  always_comb begin
    host_rdata = '0;
    if (host_addr == ADDR_W'(REG_MODE)) begin
      host_rdata = mode_q;
    end else if (host_addr == ADDR_W'(REG_TCMD)) begin
      host_rdata = tcmd_q;
    end else if (host_addr == ADDR_W'(REG_STAT)) begin
      host_rdata = stat_w;
    end else if (host_addr == ADDR_W'(REG_DATA)) begin
      host_rdata = latch_i;
    end
  end

  AST_DMA_BIT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mode_q[MODE_DMA_BIT]) |-> ($past(term_i) || $past(host_wr))); // R8

endmodule

// File: rtl/scsi_rx_hshk.sv
module scsi_rx_hshk
  import scsi_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              abort_i,
  input  logic              dma_mode_i,
  input  logic              drq_i,
  input  logic              req_i,
  input  logic [DATA_W-1:0] bus_data_i,
  output logic              ack_o,
  output logic              done_o,
  output logic [DATA_W-1:0] latch_o
);

  hs_state_e         state_q, state_d;
  logic              ack_q, ack_d;
  logic [DATA_W-1:0] latch_q;
  logic              cap_en;

  // Next-state logic of the byte handshake
  always_comb begin
    state_d = state_q;
    ack_d   = ack_q;
    done_o  = 1'b0;
    cap_en  = 1'b0;
    unique case (state_q)
      HS_IDLE: begin
        if (start_i) begin
          state_d = HS_WAIT_REQ;
        end
      end
      HS_WAIT_REQ: begin
        if (abort_i) begin
          state_d = HS_IDLE;
        end else if (req_i && !drq_i) begin
          state_d = HS_WAIT_REL;
          ack_d   = 1'b1;
          cap_en  = 1'b1;
        end
      end
      HS_WAIT_REL: begin
        if (abort_i) begin
          state_d = HS_IDLE;
          ack_d   = 1'b0;
        end else if (!req_i) begin
          ack_d   = 1'b0;
          done_o  = 1'b1;
          state_d = dma_mode_i ? HS_WAIT_REQ : HS_IDLE;
        end
      end
      default: begin
        state_d = HS_IDLE;
        ack_d   = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= HS_IDLE;
      ack_q   <= 1'b0;
      latch_q <= '0;
    end else begin
      state_q <= state_d;
      ack_q   <= ack_d;
      if (cap_en) begin
        latch_q <= bus_data_i;
      end
    end
  end

  assign ack_o   = ack_q;
  assign latch_o = latch_q;

  AST_NO_ACK_WITH_DRQ: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |-> !drq_i); // R6

  AST_ACK_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_q) |-> $past(req_i)); // R3

  AST_ACK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_q && req_i && !abort_i) |=> ack_q); // R4

endmodule

// File: rtl/scsi_rx_dreq.sv
module scsi_rx_dreq (
  input  logic clk,
  input  logic rst_n,
  input  logic done_i,
  input  logic dma_rd_i,
  input  logic dma_mode_i,
  input  logic bsy_i,
  input  logic pm_i,
  input  logic mode_wr_i,
  output logic drq_o,
  output logic eod_o,
  output logic term_o
);

  logic drq_q, drq_d;
  logic eod_q, eod_d;

  // Termination: target gone or phase changed while DMA is armed
  assign term_o = dma_mode_i && (!bsy_i || !pm_i);

  // Set and clear are idempotent: a set of a set flag changes nothing else
  always_comb begin
    drq_d = drq_q;
    if (dma_rd_i) begin
      drq_d = 1'b0;
    end
    if (done_i) begin
      drq_d = 1'b1;
    end
    if (term_o) begin
      drq_d = 1'b0;
    end
  end

  always_comb begin
    eod_d = eod_q;
    if (mode_wr_i) begin
      eod_d = 1'b0;
    end
    if (term_o) begin
      eod_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drq_q <= 1'b0;
      eod_q <= 1'b0;
    end else begin
      if (dma_rd_i || done_i || term_o) begin
        drq_q <= drq_d;
      end
      if (mode_wr_i || term_o) begin
        eod_q <= eod_d;
      end
    end
  end

  assign drq_o = drq_q;
  assign eod_o = eod_q;

  AST_TERM_DROPS_DRQ: assert property (@(posedge clk) disable iff (!rst_n)
    term_o |=> (!drq_q && eod_q)); // R8

  AST_DRQ_FROM_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drq_q) |-> $past(done_i)); // R5

  AST_EOD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr_i && !term_o) |=> !eod_q); // R11

endmodule

// File: rtl/scsi_dma_rx.sv
module scsi_dma_rx
  import scsi_rx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              scsi_req,
  input  logic              scsi_bsy,
  input  logic              scsi_msg,
  input  logic              scsi_cd,
  input  logic              scsi_io,
  input  logic [DATA_W-1:0] scsi_data,
  output logic              scsi_ack,
  output logic              dma_req,
  input  logic              dma_rd,
  output logic [DATA_W-1:0] dma_data
);

  localparam int CTL_W = PHASE_W + 2;

  logic [1:0]        rst_pipe_q;
  logic              rst_sync_n;
  logic [CTL_W-1:0]  ctl_raw, ctl_s;
  logic              req_s, bsy_s;
  phase_t            phase_s;
  logic              dma_mode, start, mode_wr, pm;
  logic              term, done, drq, eod, ack;
  logic [DATA_W-1:0] latch;

  // Reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe_q[1];

  assign ctl_raw = {scsi_req, scsi_bsy, scsi_msg, scsi_cd, scsi_io};

  scsi_rx_sync #(.WIDTH(CTL_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d     (ctl_raw),
    .q     (ctl_s)
  );

  assign req_s   = ctl_s[CTL_W-1];
  assign bsy_s   = ctl_s[CTL_W-2];
  assign phase_s = phase_t'(ctl_s[PHASE_W-1:0]);

  scsi_rx_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .host_wr     (host_wr),
    .host_addr   (host_addr),
    .host_wdata  (host_wdata),
    .term_i      (term),
    .bus_phase_i (phase_s),
    .bsy_i       (bsy_s),
    .req_i       (req_s),
    .ack_i       (ack),
    .drq_i       (drq),
    .eod_i       (eod),
    .latch_i     (latch),
    .host_rdata  (host_rdata),
    .dma_mode_o  (dma_mode),
    .start_o     (start),
    .mode_wr_o   (mode_wr),
    .pm_o        (pm)
  );

  scsi_rx_hshk #(.DATA_W(DATA_W)) u_hshk (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .start_i    (start),
    .abort_i    (term),
    .dma_mode_i (dma_mode),
    .drq_i      (drq),
    .req_i      (req_s),
    .bus_data_i (scsi_data),
    .ack_o      (ack),
    .done_o     (done),
    .latch_o    (latch)
  );

  scsi_rx_dreq u_dreq (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .done_i     (done),
    .dma_rd_i   (dma_rd),
    .dma_mode_i (dma_mode),
    .bsy_i      (bsy_s),
    .pm_i       (pm),
    .mode_wr_i  (mode_wr),
    .drq_o      (drq),
    .eod_o      (eod),
    .term_o     (term)
  );

  assign scsi_ack = ack;
  assign dma_req  = drq;
  assign dma_data = latch;

  AST_DRQ_ALIGNS_ACK: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(dma_req) |-> $fell(scsi_ack)); // R5

endmodule

// File: tb/scsi_dma_rx_bench.sv
module scsi_dma_rx_bench;

  localparam int CLK_PERIOD = 10;
  localparam int DW         = 8;
  localparam int AW         = 3;
  localparam int WD_LIMIT   = 100000;

  localparam logic [AW-1:0] A_MODE  = 3'd0;
  localparam logic [AW-1:0] A_TCMD  = 3'd1;
  localparam logic [AW-1:0] A_STAT  = 3'd2;
  localparam logic [AW-1:0] A_START = 3'd3;
  localparam logic [AW-1:0] A_DATA  = 3'd4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          host_wr;
  logic [AW-1:0] host_addr;
  logic [DW-1:0] host_wdata;
  logic [DW-1:0] host_rdata;
  logic          scsi_req, scsi_bsy, scsi_msg, scsi_cd, scsi_io;
  logic [DW-1:0] scsi_data;
  logic          scsi_ack;
  logic          dma_req;
  logic          dma_rd;
  logic [DW-1:0] dma_data;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scsi_dma_rx u_scsi_dma_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_wr    (host_wr),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .scsi_req   (scsi_req),
    .scsi_bsy   (scsi_bsy),
    .scsi_msg   (scsi_msg),
    .scsi_cd    (scsi_cd),
    .scsi_io    (scsi_io),
    .scsi_data  (scsi_data),
    .scsi_ack   (scsi_ack),
    .dma_req    (dma_req),
    .dma_rd     (dma_rd),
    .dma_data   (dma_data)
  );

  // Expected-value functions taken from the requirements
  function automatic bit exp_pm(input bit m, input bit c, input bit i, input logic [7:0] t);
    return ({m, c, i} == t[2:0]);
  endfunction

  function automatic logic [7:0] exp_stat(input bit eod, input bit pmv, input bit drq,
                                          input bit bsy, input bit req, input bit ack);
    return {2'b00, ack, req, bsy, drq, pmv, eod};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reg(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    host_wr    = 1'b1;
    host_addr  = a;
    host_wdata = d;
    @(negedge clk);
    host_wr    = 1'b0;
  endtask

  task automatic rd_reg(input logic [AW-1:0] a, output logic [7:0] v);
    host_addr = a;
    #1;
    v = host_rdata;
  endtask

  task automatic dma_pop();
    @(negedge clk);
    dma_rd = 1'b1;
    @(negedge clk);
    dma_rd = 1'b0;
  endtask

  // Target side of one byte, with timing checks on ACK and DRQ
  task automatic xfer(input logic [7:0] b);
    bit          seen;
    logic [7:0]  v;
    @(negedge clk);
    scsi_data = b;
    scsi_req  = 1'b1;
    seen = 1'b0;
    for (int i = 0; i < 20 && !seen; i++) begin
      @(negedge clk);
      if (scsi_ack) seen = 1'b1;
    end
    chk(seen, "R3 ack after req", int'(seen), 1);
    chk(dma_req == 1'b0, "R5 no drq while ack", int'(dma_req), 0);
    idle(3);
    chk(scsi_ack == 1'b1, "R4 ack held", int'(scsi_ack), 1);
    scsi_req = 1'b0;
    seen = 1'b0;
    for (int i = 0; i < 20 && !seen; i++) begin
      @(negedge clk);
      if (!scsi_ack) seen = 1'b1;
      else if (dma_req) chk(1'b0, "R5 drq before ack drop", int'(dma_req), 0);
    end
    chk(seen, "R4 ack released", int'(scsi_ack), 0);
    chk(dma_req == 1'b1, "R5 drq with ack fall", int'(dma_req), 1);
    chk(dma_data == b, "R10 dma_data", int'(dma_data), int'(b));
    rd_reg(A_DATA, v);
    chk(v == b, "R10 data reg", int'(v), int'(b));
  endtask

  initial begin : watchdog
    repeat (WD_LIMIT) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired act=%0d exp=%0d", WD_LIMIT, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [7:0] v;
    logic [7:0] t;
    logic [7:0] b;
    void'($urandom(32'h5C51));
    rst_n = 1'b0; host_wr = 1'b0; host_addr = '0; host_wdata = '0;
    scsi_req = 1'b0; scsi_bsy = 1'b0; scsi_msg = 1'b0; scsi_cd = 1'b0; scsi_io = 1'b0;
    scsi_data = '0; dma_rd = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(5);

    // R1 reset state
    chk(scsi_ack == 1'b0, "R1 ack", int'(scsi_ack), 0);
    chk(dma_req == 1'b0, "R1 drq", int'(dma_req), 0);
    rd_reg(A_MODE, v); chk(v == 8'h00, "R1 mode", int'(v), 0);
    rd_reg(A_TCMD, v); chk(v == 8'h00, "R1 tcmd", int'(v), 0);
    rd_reg(A_STAT, v); t = exp_stat(0, 1, 0, 0, 0, 0);
    chk(v == t, "R1 status", int'(v), int'(t));

    // R2 / R12 random phase against random target register
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      scsi_msg = 1'($urandom);
      scsi_cd  = 1'($urandom);
      scsi_io  = 1'($urandom);
      t = 8'($urandom);
      wr_reg(A_TCMD, t);
      idle(4);
      rd_reg(A_TCMD, v);
      chk(v == t, "R12 tcmd readback", int'(v), int'(t));
      rd_reg(A_STAT, v);
      chk(v[1] == exp_pm(scsi_msg, scsi_cd, scsi_io, t), "R2 phase match",
          int'(v[1]), int'(exp_pm(scsi_msg, scsi_cd, scsi_io, t)));
    end

    // Data-in phase, target on bus
    @(negedge clk);
    scsi_msg = 1'b0; scsi_cd = 1'b0; scsi_io = 1'b1; scsi_bsy = 1'b1;
    wr_reg(A_TCMD, 8'h01);
    idle(4);

    // Single byte without DMA mode (R3 R4 R5 R10)
    wr_reg(A_START, 8'h00);
    xfer(8'hA5);
    rd_reg(A_STAT, v); t = exp_stat(0, 1, 1, 1, 0, 0);
    chk(v == t, "R12 status after byte", int'(v), int'(t));
    dma_pop();
    chk(dma_req == 1'b0, "R6 dma_rd clears", int'(dma_req), 0);
    // R7: no automatic next byte without DMA mode
    scsi_req = 1'b1;
    idle(10);
    chk(scsi_ack == 1'b0, "R7 idle after one byte", int'(scsi_ack), 0);
    scsi_req = 1'b0;
    idle(4);

    // R9: BSY loss outside DMA mode leaves DRQ and end flag alone
    wr_reg(A_START, 8'h00);
    xfer(8'h3C);
    scsi_bsy = 1'b0;
    idle(6);
    chk(dma_req == 1'b1, "R9 drq kept", int'(dma_req), 1);
    rd_reg(A_STAT, v);
    chk(v[0] == 1'b0, "R9 no end flag", int'(v[0]), 0);
    scsi_bsy = 1'b1;
    dma_pop();
    idle(4);

    // DMA mode stream with random data and read delays (R6 R7)
    wr_reg(A_MODE, 8'h02);
    rd_reg(A_MODE, v); chk(v == 8'h02, "R12 mode readback", int'(v), 2);
    wr_reg(A_START, 8'h00);
    for (int k = 0; k < 24; k++) begin
      b = 8'($urandom);
      xfer(b);
      if (k % 3 == 0) begin
        scsi_req  = 1'b1;
        scsi_data = 8'($urandom);
        idle(8);
        chk(scsi_ack == 1'b0, "R6 no ack while drq", int'(scsi_ack), 0);
        scsi_req = 1'b0;
        idle(3);
      end else begin
        idle(int'($urandom % 5));
      end
      dma_pop();
      chk(dma_req == 1'b0, "R6 drq cleared", int'(dma_req), 0);
    end

    // R8: BSY loss in DMA mode with DRQ pending
    xfer(8'h77);
    scsi_bsy = 1'b0;
    idle(6);
    chk(dma_req == 1'b0, "R8 drq cleared by bsy loss", int'(dma_req), 0);
    rd_reg(A_MODE, v); chk(v == 8'h00, "R8 dma bit cleared", int'(v), 0);
    rd_reg(A_STAT, v); chk(v[0] == 1'b1, "R8 end flag", int'(v[0]), 1);

    // R11: mode write clears the end flag
    wr_reg(A_MODE, 8'h00);
    idle(2);
    rd_reg(A_STAT, v); chk(v[0] == 1'b0, "R11 end flag cleared", int'(v[0]), 0);

    // R8: phase mismatch while ACK is held
    scsi_bsy = 1'b1;
    idle(4);
    wr_reg(A_MODE, 8'h02);
    wr_reg(A_START, 8'h00);
    @(negedge clk);
    scsi_data = 8'h5A;
    scsi_req  = 1'b1;
    for (int i = 0; i < 20 && !scsi_ack; i++) @(negedge clk);
    chk(scsi_ack == 1'b1, "R3 ack before mismatch", int'(scsi_ack), 1);
    scsi_io = 1'b0;
    idle(6);
    chk(scsi_ack == 1'b0, "R8 ack released on mismatch", int'(scsi_ack), 0);
    chk(dma_req == 1'b0, "R8 no drq on abort", int'(dma_req), 0);
    rd_reg(A_STAT, v); chk(v[0] == 1'b1, "R8 end flag on mismatch", int'(v[0]), 1);
    scsi_req = 1'b0;
    idle(4);
    chk(dma_req == 1'b0, "R8 no late drq", int'(dma_req), 0);
    scsi_io = 1'b1;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule